// File: doc/BRIEF.md
# Burst Address Sequencer

This block is the address path of a pipelined synchronous memory port. A single external address is captured on a load cycle. On the cycles that follow, the block produces the remaining addresses of a four-beat burst on its own, so no new address needs to be driven. Only the low burst-field bits of the internal address move. The upper bits stay at the captured value for the whole burst.

The beat order is chosen per burst by a mode input, which is captured together with the address. The linear order counts upward and wraps inside the aligned group of four: starting from 01 it gives 01, 10, 11, 00. The interleaved order XORs the captured low bits with the beat number: starting from 01 it gives 01, 00, 11, 10. An active-low clock enable freezes the whole sequence for as long as it is held high. The burst is paused, not abandoned.

Control is a two-state machine.
- ST_IDLE: no address has been captured since reset.
- ST_BURST: a burst is in progress.

The transitions are:
- T_LOAD: ST_IDLE to ST_BURST, on an enabled load.
- T_WAIT: ST_IDLE stays in ST_IDLE, on any other cycle.
- T_RELOAD: ST_BURST stays in ST_BURST, on an enabled load. The burst restarts.
- T_STEP: ST_BURST stays in ST_BURST, on an enabled advance.
- T_HOLD: ST_BURST stays in ST_BURST, while the clock enable is high.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset is released and before any load, `addr_out` is all zeros and `burst_index` is 0.
- R2: On a rising edge with `cen_n`=0 and `adv_ld_n`=0, `addr_out` takes the value of `addr_in` and `burst_index` becomes 0. Both are visible after that edge.
- R3: On a rising edge with `cen_n`=0 and `adv_ld_n`=1 in ST_BURST, `burst_index` increases by 1, modulo 4.
- R4: With `mode`=0 captured at load, the low two bits of `addr_out` equal the captured low bits plus `burst_index`, modulo 4. From 00, 01, 10 and 11 the orders are 00-01-10-11, 01-10-11-00, 10-11-00-01 and 11-00-01-10.
- R5: With `mode`=1 captured at load, the low two bits of `addr_out` equal the captured low bits XOR `burst_index`. From 00, 01, 10 and 11 the orders are 00-01-10-11, 01-00-11-10, 10-11-00-01 and 11-10-01-00.
- R6: After the fourth beat, a further advance returns to the starting address with `burst_index` 0. The burst stays inside its aligned group of four.
- R7: Advancing never changes `addr_out` bits above the low two.
- R8: While `cen_n`=1, `addr_out` and `burst_index` hold their values whatever `adv_ld_n`, `addr_in` and `mode` do. Once enabled again, the burst resumes from the held beat.
- R9: `mode` is used only on a load cycle. Changing it during a burst does not change the order of that burst.
- R10: In ST_IDLE an enabled advance has no effect: `addr_out` stays 0 and `burst_index` stays 0.
- R11: A load in the middle of a burst restarts at the new address with `burst_index` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cen_n | input | 1 | Clock enable, active low; high freezes the sequence |
| adv_ld_n | input | 1 | Low loads a new address; high advances the burst |
| mode | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| addr_in | input | ADDR_W | External address captured on load |
| addr_out | output | ADDR_W | Current internal address |
| burst_index | output | CNT_W | Beat position in the burst, 0 to 3 |

## Verification
The bench builds the block with ADDR_W=10 and CNT_W=2.

The ten-bit address lets it drive addresses such as 0x3FF and 0x2A6. In these, every upper bit is set, or the upper bits form a pattern next to the burst field, so any leakage of the low-bit arithmetic into bit 2 and above shows on the port. With the two-bit counter, every starting beat in both orders, and the wrap from the fourth beat back to the first, is reached within a few cycles of each load.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } seq_state_e;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;

endpackage

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
    import burst_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cen_n,
    input  logic       adv_ld_n,
    output seq_state_e state_o,
    output logic       load_o,
    output logic       step_o
);

    seq_state_e state_q;
    seq_state_e state_d;
    logic       enabled;

    assign enabled = ~cen_n;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (enabled && !adv_ld_n) state_d = ST_BURST;   // T_LOAD
                else                      state_d = ST_IDLE;    // T_WAIT
            end
            ST_BURST: begin
                state_d = ST_BURST;                             // T_RELOAD / T_STEP / T_HOLD
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        load_o = 1'b0;
        step_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load_o = enabled && !adv_ld_n;
            end
            ST_BURST: begin
                load_o = enabled && !adv_ld_n;
                step_o = enabled &&  adv_ld_n;
            end
            default: begin
                load_o = 1'b0;
                step_o = 1'b0;
            end
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/bseq_base.sv
module bseq_base
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              mode,
    output logic [ADDR_W-1:0] base_q,
    output burst_order_e      order_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            order_q <= ORD_LINEAR;
        end else if (load) begin
            base_q  <= addr_in;
            order_q <= burst_order_e'(mode);
        end
    end

endmodule

// File: rtl/bseq_counter.sv
module bseq_counter #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    output logic [CNT_W-1:0] cnt_q
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clear) cnt_q <= '0;
        else if (step)  cnt_q <= cnt_q + ONE;   // wraps inside the group
    end

endmodule

// File: rtl/bseq_order.sv
module bseq_order
    import burst_seq_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic [CNT_W-1:0] start_lo,
    input  logic [CNT_W-1:0] beat,
    input  burst_order_e     order,
    output logic [CNT_W-1:0] lo_out
);

    logic [CNT_W-1:0] lin_lo;
    logic [CNT_W-1:0] xor_lo;

    assign lin_lo = start_lo + beat;

    for (genvar b = 0; b < CNT_W; b++) begin : g_xor_bit
        assign xor_lo[b] = start_lo[b] ^ beat[b];
    end

    always_comb begin
        unique case (order)
            ORD_LINEAR:     lo_out = lin_lo;
            ORD_INTERLEAVE: lo_out = xor_lo;
            default:        lo_out = lin_lo;
        endcase
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cen_n,
    input  logic              adv_ld_n,
    input  logic              mode,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic [CNT_W-1:0]  burst_index
);

    seq_state_e       state;
    logic             load;
    logic             step;
    logic [ADDR_W-1:0] base_q;
    burst_order_e     mode_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lo_out;

    bseq_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cen_n    (cen_n),
        .adv_ld_n (adv_ld_n),
        .state_o  (state),
        .load_o   (load),
        .step_o   (step)
    );

    bseq_base #(.ADDR_W(ADDR_W)) u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .addr_in (addr_in),
        .mode    (mode),
        .base_q  (base_q),
        .order_q (mode_q)
    );

    bseq_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (load),
        .step  (step),
        .cnt_q (cnt_q)
    );

    bseq_order #(.CNT_W(CNT_W)) u_order (
        .start_lo (base_q[CNT_W-1:0]),
        .beat     (cnt_q),
        .order    (mode_q),
        .lo_out   (lo_out)
    );

    assign addr_out    = {base_q[ADDR_W-1:CNT_W], lo_out};
    assign burst_index = cnt_q;

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cen_n,
    input logic              adv_ld_n,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out,
    input logic [CNT_W-1:0]  burst_index,
    input seq_state_e        state,
    input burst_order_e      mode_q
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic adv_burst;
    assign adv_burst = !cen_n && adv_ld_n && (state == ST_BURST);

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && !adv_ld_n) |=> (addr_out == $past(addr_in) && burst_index == '0));

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        adv_burst |=> (burst_index == $past(burst_index) + ONE));

    p_linear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_burst && mode_q == ORD_LINEAR) |=>
            (addr_out[CNT_W-1:0] == $past(addr_out[CNT_W-1:0]) + ONE));

    p_interleave_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_burst && mode_q == ORD_INTERLEAVE) |=>
            ((addr_out[CNT_W-1:0] ^ burst_index) == $past(addr_out[CNT_W-1:0] ^ burst_index)));

    p_upper_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && adv_ld_n) |=> $stable(addr_out[ADDR_W-1:CNT_W]));

    p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cen_n |=> ($stable(addr_out) && $stable(burst_index)));

    p_mode_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        adv_burst |=> $stable(mode_q));

    p_idle_adv_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !(!cen_n && !adv_ld_n)) |=>
            (addr_out == '0 && burst_index == '0));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cen_n       (cen_n),
    .adv_ld_n    (adv_ld_n),
    .addr_in     (addr_in),
    .addr_out    (addr_out),
    .burst_index (burst_index),
    .state       (state),
    .mode_q      (mode_q)
);

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;

    localparam int AW = 10;
    localparam int CW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cen_n = 1'b1;
    logic          adv_ld_n = 1'b1;
    logic          mode = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;
    logic [CW-1:0] burst_index;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW), .CNT_W(CW)) u_burst_addr_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cen_n       (cen_n),
        .adv_ld_n    (adv_ld_n),
        .mode        (mode),
        .addr_in     (addr_in),
        .addr_out    (addr_out),
        .burst_index (burst_index)
    );

    function automatic logic [AW-1:0] expect_addr(logic [AW-1:0] start, logic [1:0] idx, logic m);
        logic [1:0] lo;
        lo = m ? (start[1:0] ^ idx) : 2'((start[1:0] + idx) % 4);
        return {start[AW-1:2], lo};
    endfunction

    task automatic check(string req, logic [AW-1:0] ea, logic [CW-1:0] ei);
        n_checks++;
        if (addr_out !== ea || burst_index !== ei) begin
            n_errors++;
            $display("FAIL %s: addr_out=%h burst_index=%0d expected addr_out=%h burst_index=%0d",
                     req, addr_out, burst_index, ea, ei);
        end
    endtask

    // drive at negedge, let one rising edge pass, return at the next negedge
    task automatic cycle(logic c, logic a, logic m, logic [AW-1:0] ad);
        cen_n = c; adv_ld_n = a; mode = m; addr_in = ad;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cen_n = 1'b1; adv_ld_n = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // R1
    task automatic t_reset();
        do_reset();
        check("R1", '0, '0);
    endtask

    // R2, R3, R4/R5, R6, R7: full burst from one start address
    task automatic t_burst(logic [AW-1:0] start, logic m);
        string oreq;
        oreq = m ? "R5" : "R4";
        cycle(1'b0, 1'b0, m, start);
        check("R2", start, 2'd0);
        for (int i = 1; i < 4; i++) begin
            cycle(1'b0, 1'b1, ~m, ~start);
            check(oreq, expect_addr(start, 2'(i), m), 2'(i));
            check("R3", expect_addr(start, 2'(i), m), 2'(i));
        end
        n_checks++;
        if (addr_out[AW-1:2] !== start[AW-1:2]) begin
            n_errors++;
            $display("FAIL R7: upper=%h expected upper=%h", addr_out[AW-1:2], start[AW-1:2]);
        end
        cycle(1'b0, 1'b1, m, start);
        check("R6", start, 2'd0);
    endtask

    // R8
    task automatic t_stall();
        logic [AW-1:0] a;
        a = 10'h2A6;
        cycle(1'b0, 1'b0, 1'b0, a);
        cycle(1'b0, 1'b1, 1'b0, a);
        check("R8", expect_addr(a, 2'd1, 1'b0), 2'd1);
        cycle(1'b1, 1'b0, 1'b1, 10'h155);
        check("R8", expect_addr(a, 2'd1, 1'b0), 2'd1);
        cycle(1'b1, 1'b1, 1'b1, 10'h0F0);
        check("R8", expect_addr(a, 2'd1, 1'b0), 2'd1);
        cycle(1'b0, 1'b1, 1'b1, 10'h0F0);
        check("R8", expect_addr(a, 2'd2, 1'b0), 2'd2);
    endtask

    // R9
    task automatic t_mode_change();
        logic [AW-1:0] a;
        a = 10'h1C5;
        cycle(1'b0, 1'b0, 1'b1, a);
        for (int i = 1; i < 4; i++) begin
            cycle(1'b0, 1'b1, 1'b0, '0);
            check("R9", expect_addr(a, 2'(i), 1'b1), 2'(i));
        end
    endtask

    // R10
    task automatic t_idle_advance();
        do_reset();
        for (int i = 0; i < 3; i++) begin
            cycle(1'b0, 1'b1, 1'b1, 10'h3FF);
            check("R10", '0, '0);
        end
    endtask

    // R11
    task automatic t_reload();
        cycle(1'b0, 1'b0, 1'b0, 10'h101);
        cycle(1'b0, 1'b1, 1'b0, '0);
        cycle(1'b0, 1'b1, 1'b0, '0);
        check("R11", 10'h103, 2'd2);
        cycle(1'b0, 1'b0, 1'b1, 10'h3FE);
        check("R11", 10'h3FE, 2'd0);
        cycle(1'b0, 1'b1, 1'b0, '0);
        check("R11", 10'h3FF, 2'd1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        t_reset();
        t_idle_advance();
        for (int s = 0; s < 4; s++) begin
            t_burst({8'hA5, 2'(s)}, 1'b0);
            t_burst({8'hFF, 2'(s)}, 1'b1);
        end
        t_burst(10'h3FF, 1'b0);
        t_stall();
        t_mode_change();
        t_reload();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule